// File: doc/BRIEF.md
# Ternary Match Search Pipeline

This block is a small ternary lookup table with 64 locations of 68 bits each. Each even/odd pair of locations forms one 136-bit entry. A search key arrives in two halves on consecutive cycles: the even half first, then the odd half together with the number of a comparand slot. Every pair whose valid bit is set is compared against the key. Stored per-bit masks and a table-wide mask can exclude key bits from the comparison. The lowest-numbered matching pair wins.

The winner's even location address comes out a fixed number of cycles after the second key cycle, qualified by a one-cycle strobe. A second strobe, carrying the hit/miss result, can be pushed up to seven cycles later than the address by a 3-bit setting. Each key is also kept in the selected even/odd comparand slot, and a read port can return that slot.

Table words, masks, the table-wide mask and the pair valid bits are loaded through a single-cycle write port. A new search can start every second cycle.

Top module: `tcam_search`

## Requirements
- R1: A search is issued by asserting `key_a` for one cycle with the even key half on `key_data`, then `key_b` in the very next cycle with the odd half. `key_a` and `key_b` are never high together, so at most one search starts every two cycles.
- R2: On the `key_b` cycle the whole key is stored in comparand slot `cmp_idx`. One cycle after `cmp_rd_idx` is set, `cmp_rd_even` and `cmp_rd_odd` show the even and odd halves of that slot. Other slots are left unchanged.
- R3: A pair matches when its valid bit is set and both halves match. A key bit is ignored wherever the stored mask bit of that location is 1. All other bits must equal the stored data.
- R4: The table-wide mask is 136 bits. It is written with `wr_kind`=2; `wr_addr[0]`=0 selects the even half and 1 the odd half. A mask bit of 1 makes that key bit don't-care for every entry.
- R5: When several pairs match, the lowest pair index wins. The reported address is twice the pair index, so a hit is always at an even location.
- R6: `res_strobe` pulses for one cycle, and `res_addr` is valid, at the 6th rising edge after the edge that samples `key_b`. Searches issued every two cycles produce results every two cycles, in order.
- R7: `flag_valid` and `flag_hit` for a search appear `flag_dly` cycles (0 to 7) after its `res_strobe`.
- R8: On a miss, `res_strobe` and `flag_valid` still pulse, with `res_addr`=0 and `flag_hit`=0.
- R9: Writes take effect at the sampling edge. `wr_kind` selects what is written: 0 = location data, 1 = location mask, 3 = valid bit of pair `wr_addr[5:1]` taken from `wr_data[0]`. A write committed at any edge after a search's `key_b` edge does not change that search's result.
- R10: After reset, all outputs are 0, every pair is invalid, the table-wide mask is 0 and every comparand slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_a | input | 1 | Even-half key cycle |
| key_b | input | 1 | Odd-half key cycle; starts the search |
| key_data | input | 68 | Key half |
| cmp_idx | input | 2 | Comparand slot written on the `key_b` cycle |
| cmp_rd_idx | input | 2 | Comparand slot to read |
| cmp_rd_even | output | 68 | Even half of the slot being read |
| cmp_rd_odd | output | 68 | Odd half of the slot being read |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 data, 1 mask, 2 table-wide mask, 3 pair valid |
| wr_addr | input | 6 | Location (or mask half / pair) address |
| wr_data | input | 68 | Write data |
| flag_dly | input | 3 | Extra delay of the flags after the address |
| res_addr | output | 6 | Winning even location, 0 on a miss |
| res_strobe | output | 1 | Result address valid |
| flag_valid | output | 1 | Delayed result-flag strobe |
| flag_hit | output | 1 | Delayed hit indication |

## Verification
The assertions check, on every cycle, the two-cycle key protocol and the even-address and zero-on-miss rules of the result. They also check that a valid-bit write lands in the addressed pair. Only the bench scenarios can show that the lowest match wins, that masks and the table-wide mask take effect, and that the result arrives exactly six edges after the key. They also cover the flag delay for several settings, a write that races a search in flight, back-to-back searches, and comparand readback.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    WR_DATA  = 2'b00,
    WR_MASK  = 2'b01,
    WR_GMASK = 2'b10,
    WR_VALID = 2'b11
  } wr_kind_e;
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int HALF_W = 68,
  parameter int LOCS   = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  tcam_pkg::wr_kind_e        wr_kind,
  input  logic [$clog2(LOCS)-1:0]   wr_addr,
  input  logic [HALF_W-1:0]         wr_data,
  input  logic                      srch_go,
  input  logic [HALF_W-1:0]         key_even,
  input  logic [HALF_W-1:0]         key_odd,
  output logic [LOCS/2-1:0]         match_q,
  output logic                      go_q
);
  import tcam_pkg::*;
  localparam int PAIRS = LOCS / 2;
  localparam int AW    = $clog2(LOCS);

  logic [HALF_W-1:0] dat_mem [LOCS];
  logic [HALF_W-1:0] msk_mem [LOCS];
  logic [HALF_W-1:0] gm_even, gm_odd;
  logic [PAIRS-1:0]  vld;
  logic [PAIRS-1:0]  pair_hit;

  // table words: plain write-only arrays, no reset
  always_ff @(posedge clk) begin
    if (wr_en && wr_kind == WR_DATA) dat_mem[wr_addr] <= wr_data;
    if (wr_en && wr_kind == WR_MASK) msk_mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gm_even <= '0;
      gm_odd  <= '0;
      vld     <= '0;
    end else if (wr_en) begin
      if (wr_kind == WR_GMASK) begin
        if (wr_addr[0]) gm_odd  <= wr_data;
        else            gm_even <= wr_data;
      end
      if (wr_kind == WR_VALID) vld[wr_addr[AW-1:1]] <= wr_data[0];
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic eq_even, eq_odd;
    assign eq_even = ~|((dat_mem[2*p]   ^ key_even) & ~msk_mem[2*p]   & ~gm_even);
    assign eq_odd  = ~|((dat_mem[2*p+1] ^ key_odd)  & ~msk_mem[2*p+1] & ~gm_odd);
    assign pair_hit[p] = vld[p] & eq_even & eq_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q    <= srch_go;
      match_q <= srch_go ? pair_hit : '0;
    end
  end

  // R9
  vld_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == WR_VALID) |=> (vld[$past(wr_addr[AW-1:1])] == $past(wr_data[0])));
endmodule

// File: rtl/tcam_resolve.sv
module tcam_resolve #(
  parameter int LOCS    = 64,
  parameter int LAT     = 6,
  parameter int SHIFT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go_in,
  input  logic [LOCS/2-1:0]        match_in,
  input  logic [SHIFT_W-1:0]       flag_dly,
  output logic [$clog2(LOCS)-1:0]  res_addr,
  output logic                     res_strobe,
  output logic                     flag_valid,
  output logic                     flag_hit
);
  localparam int PAIRS = LOCS / 2;
  localparam int PW    = $clog2(PAIRS);
  localparam int NDLY  = LAT - 3;
  localparam int NSH   = (1 << SHIFT_W) - 1;

  typedef struct packed {
    logic          v;
    logic          hit;
    logic [PW-1:0] pair;
  } slot_t;

  logic          enc_hit;
  logic [PW-1:0] enc_pair;
  slot_t         s2;
  slot_t         dly [NDLY];
  slot_t         tail;
  logic [1:0]    sh [NSH];
  logic          res_hit_q;

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    enc_hit  = 1'b0;
    enc_pair = '0;
    for (int i = PAIRS - 1; i >= 0; i--) begin
      if (match_in[i]) begin
        enc_hit  = 1'b1;
        enc_pair = PW'(i);
      end
    end
  end

  assign tail = dly[NDLY-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      s2         <= '0;
      res_addr   <= '0;
      res_strobe <= 1'b0;
      res_hit_q  <= 1'b0;
      flag_valid <= 1'b0;
      flag_hit   <= 1'b0;
      for (int i = 0; i < NDLY; i++) dly[i] <= '0;
      for (int i = 0; i < NSH; i++)  sh[i]  <= '0;
    end else begin
      s2     <= '{v: go_in, hit: go_in & enc_hit, pair: enc_pair};
      dly[0] <= s2;
      for (int i = 1; i < NDLY; i++) dly[i] <= dly[i-1];
      res_strobe <= tail.v;
      res_hit_q  <= tail.hit;
      res_addr   <= tail.hit ? {tail.pair, 1'b0} : '0;
      sh[0] <= {tail.v, tail.hit};
      for (int i = 1; i < NSH; i++) sh[i] <= sh[i-1];
      if (flag_dly == '0) {flag_valid, flag_hit} <= {tail.v, tail.hit};
      else                {flag_valid, flag_hit} <= sh[flag_dly - 1'b1];
    end
  end

  // R5
  even_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (res_strobe && res_hit_q) |-> !res_addr[0]);
  // R8
  miss_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_strobe && !res_hit_q) |-> (res_addr == '0));
endmodule

// File: rtl/tcam_search.sv
module tcam_search #(
  parameter int HALF_W  = 68,
  parameter int LOCS    = 64,
  parameter int NCMP    = 4,
  parameter int LAT     = 6,
  parameter int SHIFT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     key_a,
  input  logic                     key_b,
  input  logic [HALF_W-1:0]        key_data,
  input  logic [$clog2(NCMP)-1:0]  cmp_idx,
  input  logic [$clog2(NCMP)-1:0]  cmp_rd_idx,
  output logic [HALF_W-1:0]        cmp_rd_even,
  output logic [HALF_W-1:0]        cmp_rd_odd,
  input  logic                     wr_en,
  input  logic [1:0]               wr_kind,
  input  logic [$clog2(LOCS)-1:0]  wr_addr,
  input  logic [HALF_W-1:0]        wr_data,
  input  logic [SHIFT_W-1:0]       flag_dly,
  output logic [$clog2(LOCS)-1:0]  res_addr,
  output logic                     res_strobe,
  output logic                     flag_valid,
  output logic                     flag_hit
);
  import tcam_pkg::*;

  logic [HALF_W-1:0] half_a;
  logic [HALF_W-1:0] key_even_q, key_odd_q;
  logic              go_q0, go_q1;
  logic [LOCS/2-1:0] match_q;
  logic [HALF_W-1:0] cmp_e [NCMP];
  logic [HALF_W-1:0] cmp_o [NCMP];

  always_ff @(posedge clk) begin
    if (rst) begin
      half_a      <= '0;
      key_even_q  <= '0;
      key_odd_q   <= '0;
      go_q0       <= 1'b0;
      cmp_rd_even <= '0;
      cmp_rd_odd  <= '0;
      for (int i = 0; i < NCMP; i++) begin
        cmp_e[i] <= '0;
        cmp_o[i] <= '0;
      end
    end else begin
      go_q0 <= key_b;
      if (key_a) half_a <= key_data;
      if (key_b) begin
        key_even_q     <= half_a;
        key_odd_q      <= key_data;
        cmp_e[cmp_idx] <= half_a;
        cmp_o[cmp_idx] <= key_data;
      end
      cmp_rd_even <= cmp_e[cmp_rd_idx];
      cmp_rd_odd  <= cmp_o[cmp_rd_idx];
    end
  end

  tcam_store #(.HALF_W(HALF_W), .LOCS(LOCS)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind_e'(wr_kind)),
    .wr_addr(wr_addr), .wr_data(wr_data), .srch_go(go_q0),
    .key_even(key_even_q), .key_odd(key_odd_q),
    .match_q(match_q), .go_q(go_q1)
  );

  tcam_resolve #(.LOCS(LOCS), .LAT(LAT), .SHIFT_W(SHIFT_W)) u_resolve (
    .clk(clk), .rst(rst), .go_in(go_q1), .match_in(match_q),
    .flag_dly(flag_dly), .res_addr(res_addr), .res_strobe(res_strobe),
    .flag_valid(flag_valid), .flag_hit(flag_hit)
  );

  // R1
  b_after_a_chk: assert property (@(posedge clk) disable iff (rst)
    key_b |-> $past(key_a));
  // R1
  ab_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(key_a && key_b));
endmodule

// File: tb/tcam_search_bench.sv
module tcam_search_bench;
  localparam int HW = 68;
  localparam int VW = HW + HW + 1 + 6;
  localparam int NV = 8;
  // {even key, odd key, expected hit, expected address}
  localparam logic [VW-1:0] VEC [NV] = '{
    {68'h11, 68'h22, 1'b1, 6'd0},
    {68'h11, 68'h33, 1'b1, 6'd2},
    {68'h17, 68'h44, 1'b1, 6'd4},
    {68'h1F, 68'h44, 1'b1, 6'd4},
    {68'h20, 68'h44, 1'b0, 6'd0},
    {68'h55, 68'h66, 1'b0, 6'd0},
    {68'h77, 68'h88, 1'b1, 6'd62},
    {68'h11, 68'h88, 1'b0, 6'd0}
  };

  logic clk = 0, rst = 1;
  logic key_a = 0, key_b = 0, wr_en = 0;
  logic [HW-1:0] key_data = '0, wr_data = '0;
  logic [1:0] cmp_idx = 0, cmp_rd_idx = 0, wr_kind = 0;
  logic [5:0] wr_addr = 0;
  logic [2:0] flag_dly = 0;
  logic [HW-1:0] cmp_rd_even, cmp_rd_odd;
  logic [5:0] res_addr;
  logic res_strobe, flag_valid, flag_hit;
  int nvec = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tcam_search u_tcam_search (
    .clk(clk), .rst(rst), .key_a(key_a), .key_b(key_b), .key_data(key_data),
    .cmp_idx(cmp_idx), .cmp_rd_idx(cmp_rd_idx), .cmp_rd_even(cmp_rd_even),
    .cmp_rd_odd(cmp_rd_odd), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
    .wr_data(wr_data), .flag_dly(flag_dly), .res_addr(res_addr),
    .res_strobe(res_strobe), .flag_valid(flag_valid), .flag_hit(flag_hit)
  );

  task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [5:0] a, input logic [HW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = k; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_pair(input int p, input logic [HW-1:0] e, input logic [HW-1:0] o,
                          input logic [HW-1:0] me, input logic v);
    wr(2'd0, 6'(2*p), e);
    wr(2'd0, 6'(2*p+1), o);
    wr(2'd1, 6'(2*p), me);
    wr(2'd1, 6'(2*p+1), '0);
    wr(2'd3, 6'(2*p), HW'(v));
  endtask

  // leaves the caller at the negedge just after the key_b edge
  task automatic issue(input logic [HW-1:0] e, input logic [HW-1:0] o, input logic [1:0] idx);
    @(negedge clk);
    key_a = 1; key_data = e;
    @(negedge clk);
    key_a = 0; key_b = 1; key_data = o; cmp_idx = idx;
    @(negedge clk);
    key_b = 0;
  endtask

  task automatic expect_res(input string req, input logic h, input logic [5:0] a);
    chk(req, {res_strobe, res_addr}, {1'b1, a});
    if (flag_dly == 0) chk(req, {flag_valid, flag_hit}, {1'b1, h});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10", {res_strobe, res_addr, flag_valid, flag_hit}, '0);
    chk("R10", {cmp_rd_even, cmp_rd_odd}, '0);
    issue(68'h11, 68'h22, 2'd1);
    repeat (6) @(negedge clk);
    expect_res("R10 all invalid after reset", 1'b0, 6'd0);

    set_pair(0, 68'h11, 68'h22, 68'h0, 1);
    set_pair(1, 68'h11, 68'h33, 68'h0, 1);
    set_pair(2, 68'h10, 68'h44, 68'h0F, 1);
    set_pair(3, 68'h55, 68'h66, 68'h0, 0);
    set_pair(5, 68'h11, 68'h22, 68'h0, 1);
    set_pair(6, 68'h10, 68'h44, 68'h0F, 1);
    set_pair(31, 68'h77, 68'h88, 68'h0, 1);

    // R3 R5 R8 table of vectors
    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][VW-1 -: HW], VEC[k][VW-HW-1 -: HW], 2'(k));
      repeat (6) @(negedge clk);
      expect_res($sformatf("R3/R5/R8 vector %0d", k), VEC[k][6], VEC[k][5:0]);
    end

    // R4 table-wide mask on odd half
    wr(2'd2, 6'd1, {HW{1'b1}});
    issue(68'h11, 68'h99, 2'd0);
    repeat (6) @(negedge clk);
    expect_res("R4 odd half masked", 1'b1, 6'd0);
    wr(2'd2, 6'd1, '0);
    wr(2'd2, 6'd0, 68'hF0);
    issue(68'hE7, 68'h44, 2'd0);
    repeat (6) @(negedge clk);
    expect_res("R4 even bits masked", 1'b1, 6'd4);
    wr(2'd2, 6'd0, '0);
    issue(68'h11, 68'h99, 2'd0);
    repeat (6) @(negedge clk);
    expect_res("R4 mask cleared", 1'b0, 6'd0);

    // R2 comparand slots
    issue(68'hA1, 68'hB1, 2'd1);
    issue(68'hA2, 68'hB2, 2'd2);
    cmp_rd_idx = 2'd1;
    @(negedge clk);
    chk("R2 slot1", {cmp_rd_even, cmp_rd_odd}, {68'hA1, 68'hB1});
    cmp_rd_idx = 2'd2;
    @(negedge clk);
    chk("R2 slot2", {cmp_rd_even, cmp_rd_odd}, {68'hA2, 68'hB2});
    repeat (8) @(negedge clk);

    // R6 exact latency
    issue(68'h11, 68'h33, 2'd0);
    repeat (5) @(negedge clk);
    chk("R6 not early", {127'b0, res_strobe}, '0);
    @(negedge clk);
    expect_res("R6 on time", 1'b1, 6'd2);

    // R6 back-to-back searches every two cycles
    @(negedge clk);
    key_a = 1; key_data = 68'h11;
    @(negedge clk); key_a = 0; key_b = 1; key_data = 68'h22;
    @(negedge clk); key_b = 0; key_a = 1; key_data = 68'h77;
    @(negedge clk); key_a = 0; key_b = 1; key_data = 68'h88;
    @(negedge clk); key_b = 0; key_a = 1; key_data = 68'h20;
    @(negedge clk); key_a = 0; key_b = 1; key_data = 68'h44;
    @(negedge clk); key_b = 0;
    repeat (2) @(negedge clk);
    expect_res("R6 pipelined 1", 1'b1, 6'd0);
    repeat (2) @(negedge clk);
    expect_res("R6 pipelined 2", 1'b1, 6'd62);
    repeat (2) @(negedge clk);
    expect_res("R6 pipelined 3", 1'b0, 6'd0);

    // R7 flag delay 5 and 7
    flag_dly = 3'd5;
    repeat (10) @(negedge clk);
    issue(68'h77, 68'h88, 2'd0);
    repeat (6) @(negedge clk);
    chk("R7 addr first", {res_strobe, res_addr, flag_valid}, {1'b1, 6'd62, 1'b0});
    repeat (4) @(negedge clk);
    chk("R7 flag not early", {127'b0, flag_valid}, '0);
    @(negedge clk);
    chk("R7 flag at +5", {126'b0, flag_valid, flag_hit}, {126'b0, 2'b11});
    flag_dly = 3'd7;
    repeat (10) @(negedge clk);
    issue(68'h20, 68'h44, 2'd0);
    repeat (12) @(negedge clk);
    chk("R7 flag not early d7", {127'b0, flag_valid}, '0);
    @(negedge clk);
    chk("R8 R7 miss flag at +7", {126'b0, flag_valid, flag_hit}, {126'b0, 2'b10});
    flag_dly = 3'd0;
    repeat (10) @(negedge clk);

    // R9 write racing a search in flight
    issue(68'h11, 68'h22, 2'd0);
    wr_en = 1; wr_kind = 2'd3; wr_addr = 6'd0; wr_data = '0;
    @(negedge clk);
    wr_en = 0;
    repeat (5) @(negedge clk);
    expect_res("R9 in-flight search unaffected", 1'b1, 6'd0);
    issue(68'h11, 68'h22, 2'd0);
    repeat (6) @(negedge clk);
    expect_res("R9 R5 invalidated pair, next lowest", 1'b1, 6'd10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule